// File: doc/BRIEF.md
# Nonvolatile Memory Control Register Sequencer

This block holds the 8-bit control and status byte that a CPU uses to command an on-chip nonvolatile store. The store can be a data EEPROM, program flash or configuration space. The CPU writes the byte through a simple register port. The block turns the command bits in that byte into memory-side strobes and drives a target-space code. When a command starts, it captures the address pointer. A one-clock read is issued directly. A write or a row erase runs for a fixed number of clocks, timed by an internal down-counter, and `busy_o` is high for that whole time.

Software can only set the two command bits. Hardware clears them when the operation ends. A warm reset (external or watchdog) that arrives during a self-timed cycle stops the cycle early and records a write error. That error flag survives the warm reset, and so do the two space-select bits, so software can find out which operation was lost. A power-on reset clears the whole byte.

Top module: `nvm_ctrl_seq`

## Requirements
- R1: Power-on reset (`rst_ni` low) clears all eight register bits to 0, drops `busy_o`, and leaves all memory strobes low.
- R2: `mem_space_o` is 2'b10 (configuration) whenever bit6 is 1. Otherwise it is 2'b01 (program flash) when bit7 is 1 and 2'b00 (data EEPROM) when bit7 is 0.
- R3: A register write with bit0 = 1 sets bit0 and raises `mem_rd_o` for exactly one clock. Hardware then clears bit0.
- R4: A read request (bit0 = 1) in a written byte whose bit7 is 1 is ignored: bit0 stays 0 and `mem_rd_o` stays low.
- R5: A written byte with bit1 = 1 and bit2 (write enable) = 0 starts no operation: bit1 stays 0 and `busy_o` stays low.
- R6: A written byte with bit1 = 1 and bit2 = 1 sets bit1 and starts a cycle. Bit1, `busy_o` and `mem_wr_o` are then high for exactly WR_CYCLES clocks, after which hardware clears bit1.
- R7: If bit4 (row erase) is 1 when a cycle starts, `mem_erase_o` is driven instead of `mem_wr_o`, and hardware clears bit4 when the erase completes.
- R8: While `busy_o` is high, a register write changes only bit2. All other bits keep their values.
- R9: `mem_addr_o` carries the value of `addr_i` sampled when a read or write command was accepted, and it holds that value for the whole cycle.
- R10: A warm reset (`warm_rst_ni` low at a clock edge) during a cycle ends the cycle at that edge and sets bit3 (write error). It clears bits 4, 2, 1 and 0 and keeps bits 7 and 6.
- R11: A warm reset while idle clears bits 4, 2, 1 and 0 and keeps bits 7, 6 and 3.
- R12: A cycle that completes normally clears bit3.
- R13: When one written byte requests both a read and a write start that is accepted, the write runs and the read is ignored.
- R14: Bit5 always reads 0, whatever value is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| warm_rst_ni | input | 1 | Warm (external or watchdog) reset, active low, sampled on the clock |
| reg_we_i | input | 1 | CPU write strobe for the control byte |
| reg_wdata_i | input | 8 | CPU write data |
| reg_rdata_o | output | 8 | Current control byte |
| addr_i | input | ADDR_W | Address pointer to the memory |
| busy_o | output | 1 | Self-timed write or erase in progress |
| mem_rd_o | output | 1 | One-clock read strobe |
| mem_wr_o | output | 1 | Write strobe, high for the whole write cycle |
| mem_erase_o | output | 1 | Row erase strobe, high for the whole erase cycle |
| mem_space_o | output | 2 | Target space: 00 data, 01 flash, 10 configuration |
| mem_addr_o | output | ADDR_W | Address captured when the command was accepted |

## Verification
The bench builds the block with WR_CYCLES = 6 and ADDR_W = 8. The short cycle keeps each full write or erase within a few steps, so completion, a register write in the middle of a cycle, and a warm-reset abort after two clocks all fit in one compact run. With an 8-bit pointer, the bench can move `addr_i` to a different value during the cycle and show that the captured address does not follow it.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int B_RD    = 0;
  localparam int B_WR    = 1;
  localparam int B_WEN   = 2;
  localparam int B_ERR   = 3;
  localparam int B_ERASE = 4;
  localparam int B_SPARE = 5;
  localparam int B_CFG   = 6;
  localparam int B_PROG  = 7;

  typedef enum logic [1:0] {
    SPACE_DATA = 2'b00,
    SPACE_PROG = 2'b01,
    SPACE_CFG  = 2'b10
  } space_e;

  typedef struct packed {
    logic prog;
    logic cfg;
    logic erase_en;
    logic wr_err;
    logic wr_en;
    logic wr_go;
    logic rd_go;
  } ctrl_t;

  function automatic space_e space_of(input logic prog, input logic cfg);
    if (cfg) return SPACE_CFG;
    if (prog) return SPACE_PROG;
    return SPACE_DATA;
  endfunction
endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
  import nvm_pkg::*;
(
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  output logic       fields_we_o,
  output logic       wen_we_o,
  output logic       wr_start_o,
  output logic       rd_start_o,
  output logic       f_prog_o,
  output logic       f_cfg_o,
  output logic       f_erase_o,
  output logic       f_err_o,
  output logic       f_wen_o
);
  logic unused_spare;
  logic idle_we;

  assign unused_spare = wdata_i[B_SPARE];
  assign idle_we      = we_i && !busy_i;

  assign fields_we_o = idle_we;
  assign wen_we_o    = we_i;
  // write needs enable in the same byte
  assign wr_start_o  = idle_we && wdata_i[B_WR] && wdata_i[B_WEN];
  // flash reads blocked; a starting write wins
  assign rd_start_o  = idle_we && wdata_i[B_RD] && !wdata_i[B_PROG] && !wr_start_o;

  assign f_prog_o  = wdata_i[B_PROG];
  assign f_cfg_o   = wdata_i[B_CFG];
  assign f_erase_o = wdata_i[B_ERASE];
  assign f_err_o   = wdata_i[B_ERR];
  assign f_wen_o   = wdata_i[B_WEN];
endmodule

// File: rtl/nvm_timer.sv
module nvm_timer #(
  parameter int WR_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic abort_i,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (abort_i)                cnt_q <= '0;
    else if (start_i)                cnt_q <= LOAD;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
  import nvm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  warm_rst_ni,
  input  logic  fields_we_i,
  input  logic  wen_we_i,
  input  logic  wr_start_i,
  input  logic  rd_start_i,
  input  logic  done_i,
  input  logic  f_prog_i,
  input  logic  f_cfg_i,
  input  logic  f_erase_i,
  input  logic  f_err_i,
  input  logic  f_wen_i,
  output ctrl_t ctrl_o
);
  ctrl_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (!warm_rst_ni) begin
      // selects survive; an abort is recorded
      q.wr_err   <= q.wr_err | q.wr_go;
      q.erase_en <= 1'b0;
      q.wr_en    <= 1'b0;
      q.wr_go    <= 1'b0;
      q.rd_go    <= 1'b0;
    end else begin
      q.rd_go <= rd_start_i;
      if (fields_we_i) begin
        q.prog     <= f_prog_i;
        q.cfg      <= f_cfg_i;
        q.erase_en <= f_erase_i;
        q.wr_err   <= f_err_i;
        q.wr_en    <= f_wen_i;
      end else if (wen_we_i) begin
        q.wr_en <= f_wen_i;
      end
      if (wr_start_i) begin
        q.wr_go <= 1'b1;
      end else if (done_i) begin
        q.wr_go    <= 1'b0;
        q.wr_err   <= 1'b0;
        q.erase_en <= 1'b0;
      end
    end
  end

  assign ctrl_o = q;
endmodule

// File: rtl/nvm_mem_port.sv
module nvm_mem_port
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prog_i,
  input  logic              cfg_i,
  input  logic              erase_en_i,
  input  logic              wr_go_i,
  input  logic              rd_go_i,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              mem_erase_o,
  output logic [1:0]        mem_space_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic [ADDR_W-1:0] addr_q;
  space_e            space;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (capture_i) addr_q <= addr_i;
  end

  assign space       = space_of(prog_i, cfg_i);
  assign mem_space_o = space;
  assign mem_addr_o  = addr_q;
  assign mem_rd_o    = rd_go_i;
  assign mem_wr_o    = wr_go_i && !erase_en_i;
  assign mem_erase_o = wr_go_i && erase_en_i;
endmodule

// File: rtl/nvm_ctrl_seq.sv
module nvm_ctrl_seq
  import nvm_pkg::*;
#(
  parameter int WR_CYCLES = 16,
  parameter int ADDR_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              mem_erase_o,
  output logic [1:0]        mem_space_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  ctrl_t ctrl;
  logic  fields_we, wen_we, wr_start, rd_start, done;
  logic  f_prog, f_cfg, f_erase, f_err, f_wen;
  logic  accepted;

  nvm_cmd_decode u_dec (
    .we_i        (reg_we_i && warm_rst_ni),
    .wdata_i     (reg_wdata_i),
    .busy_i      (ctrl.wr_go),
    .fields_we_o (fields_we),
    .wen_we_o    (wen_we),
    .wr_start_o  (wr_start),
    .rd_start_o  (rd_start),
    .f_prog_o    (f_prog),
    .f_cfg_o     (f_cfg),
    .f_erase_o   (f_erase),
    .f_err_o     (f_err),
    .f_wen_o     (f_wen)
  );

  nvm_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (!warm_rst_ni),
    .start_i (wr_start),
    .run_i   (ctrl.wr_go),
    .done_o  (done)
  );

  nvm_ctrl_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_rst_ni (warm_rst_ni),
    .fields_we_i (fields_we),
    .wen_we_i    (wen_we),
    .wr_start_i  (wr_start),
    .rd_start_i  (rd_start),
    .done_i      (done),
    .f_prog_i    (f_prog),
    .f_cfg_i     (f_cfg),
    .f_erase_i   (f_erase),
    .f_err_i     (f_err),
    .f_wen_i     (f_wen),
    .ctrl_o      (ctrl)
  );

  assign accepted = wr_start || rd_start;

  nvm_mem_port #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (accepted),
    .addr_i      (addr_i),
    .prog_i      (ctrl.prog),
    .cfg_i       (ctrl.cfg),
    .erase_en_i  (ctrl.erase_en),
    .wr_go_i     (ctrl.wr_go),
    .rd_go_i     (ctrl.rd_go),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_erase_o (mem_erase_o),
    .mem_space_o (mem_space_o),
    .mem_addr_o  (mem_addr_o)
  );

  assign reg_rdata_o = {ctrl.prog, ctrl.cfg, 1'b0, ctrl.erase_en,
                        ctrl.wr_err, ctrl.wr_en, ctrl.wr_go, ctrl.rd_go};
  assign busy_o      = ctrl.wr_go;
endmodule

// File: rtl/nvm_ctrl_seq_chk.sv
module nvm_ctrl_seq_chk #(
  parameter int WR_CYCLES = 16,
  parameter int ADDR_W    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              warm_rst_ni,
  input logic              reg_we_i,
  input logic              rq_rd_i,
  input logic              rq_wr_i,
  input logic              rq_wen_i,
  input logic              st_err_i,
  input logic              st_wr_i,
  input logic              st_erase_i,
  input logic              busy_i,
  input logic              mem_rd_i,
  input logic              mem_wr_i,
  input logic              mem_erase_i,
  input logic [1:0]        mem_space_i,
  input logic [ADDR_W-1:0] mem_addr_i
);
  localparam int RW = $clog2(WR_CYCLES + 2);
  localparam logic [RW-1:0] LIM = RW'(WR_CYCLES);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_i && !(reg_we_i && rq_rd_i)) |=> !mem_rd_i); // R3
  AST_NO_FLASH_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_i |-> (mem_space_i != 2'b01)); // R4
  AST_WR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(reg_we_i && rq_wr_i && rq_wen_i)); // R5
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_i, mem_wr_i, mem_erase_i})); // R6
  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (run_q < LIM)); // R6
  AST_RUN_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && $past(warm_rst_ni)) |-> (run_q == LIM)); // R6
  AST_ERASE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_erase_i) |-> !st_erase_i); // R7
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(mem_addr_i)); // R9
  AST_WARM_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warm_rst_ni && busy_i) |=> (st_err_i && !busy_i)); // R10
  AST_DONE_CLR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && $past(warm_rst_ni)) |-> (!st_err_i && !st_wr_i)); // R12
endmodule

bind nvm_ctrl_seq nvm_ctrl_seq_chk #(.WR_CYCLES(WR_CYCLES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .warm_rst_ni (warm_rst_ni),
  .reg_we_i    (reg_we_i),
  .rq_rd_i     (reg_wdata_i[0]),
  .rq_wr_i     (reg_wdata_i[1]),
  .rq_wen_i    (reg_wdata_i[2]),
  .st_err_i    (reg_rdata_o[3]),
  .st_wr_i     (reg_rdata_o[1]),
  .st_erase_i  (reg_rdata_o[4]),
  .busy_i      (busy_o),
  .mem_rd_i    (mem_rd_o),
  .mem_wr_i    (mem_wr_o),
  .mem_erase_i (mem_erase_o),
  .mem_space_i (mem_space_o),
  .mem_addr_i  (mem_addr_o)
);

// File: tb/tb_nvm_ctrl_seq.sv
module tb_nvm_ctrl_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 6;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          warm_n = 1'b1;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [AW-1:0] addr = '0;
  logic          busy, mem_rd, mem_wr, mem_erase;
  logic [1:0]    mem_space;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_ctrl_seq #(.WR_CYCLES(WRC), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_ni(warm_n),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .addr_i(addr), .busy_o(busy), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_erase_o(mem_erase), .mem_space_o(mem_space), .mem_addr_o(mem_addr)
  );

  typedef struct {
    string      req;
    logic [7:0] r;
    logic       b;
    logic [2:0] s;   // {rd, wr, erase}
    logic [1:0] sp;
    logic       ca;
    logic [7:0] a;
  } exp_t;

  exp_t sb[$];

  function automatic exp_t mk(string req, logic [7:0] r, logic b, logic [2:0] s,
                              logic [1:0] sp, logic ca, logic [7:0] a);
    exp_t e;
    e.req = req; e.r = r; e.b = b; e.s = s; e.sp = sp; e.ca = ca; e.a = a;
    return e;
  endfunction

  task automatic step(input logic we, input logic [7:0] wd, input logic wn,
                      input logic [7:0] a, input bit chk, input exp_t e);
    @(negedge clk);
    reg_we = we; reg_wdata = wd; warm_n = wn; addr = a;
    if (chk) sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1, addr, 1'b0, mk("", 0, 0, 0, 0, 0, 0));
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        logic [14:0] got, want;
        e = sb.pop_front();
        got  = {reg_rdata, busy, mem_rd, mem_wr, mem_erase, mem_space};
        want = {e.r, e.b, e.s, e.sp};
        checks++;
        if (got !== want) begin
          fails++;
          $display("FAIL %s: rdata=%h busy=%b strobes=%b space=%b expected rdata=%h busy=%b strobes=%b space=%b",
                   e.req, reg_rdata, busy, {mem_rd, mem_wr, mem_erase}, mem_space,
                   e.r, e.b, e.s, e.sp);
        end
        if (e.ca) begin
          checks++;
          if (mem_addr !== e.a) begin
            fails++;
            $display("FAIL %s: mem_addr=%h expected %h", e.req, mem_addr, e.a);
          end
        end
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    step(0, 8'h00, 1, 8'h00, 1, mk("R1", 8'h00, 0, 3'b000, 2'b00, 0, 0));

    // R3 read of data space
    step(1, 8'h01, 1, 8'h12, 1, mk("R3", 8'h01, 0, 3'b100, 2'b00, 1, 8'h12));
    step(0, 8'h00, 1, 8'h12, 1, mk("R3", 8'h00, 0, 3'b000, 2'b00, 0, 0));

    // R14 spare bit
    step(1, 8'h20, 1, 8'h00, 1, mk("R14", 8'h00, 0, 3'b000, 2'b00, 0, 0));

    // R4 read blocked with flash selected
    step(1, 8'h81, 1, 8'h00, 1, mk("R4", 8'h80, 0, 3'b000, 2'b01, 0, 0));
    step(0, 8'h00, 1, 8'h00, 1, mk("R4", 8'h80, 0, 3'b000, 2'b01, 0, 0));

    // R2 space codes
    step(1, 8'h40, 1, 8'h00, 1, mk("R2", 8'h40, 0, 3'b000, 2'b10, 0, 0));
    step(1, 8'hC0, 1, 8'h00, 1, mk("R2", 8'hC0, 0, 3'b000, 2'b10, 0, 0));
    step(1, 8'h41, 1, 8'h07, 1, mk("R2", 8'h41, 0, 3'b100, 2'b10, 1, 8'h07));
    step(0, 8'h00, 1, 8'h07, 1, mk("R2", 8'h40, 0, 3'b000, 2'b10, 0, 0));

    // R5 write start without enable
    step(1, 8'h02, 1, 8'h00, 1, mk("R5", 8'h00, 0, 3'b000, 2'b00, 0, 0));
    step(0, 8'h00, 1, 8'h00, 1, mk("R5", 8'h00, 0, 3'b000, 2'b00, 0, 0));

    // R6 write cycle, R8 write while busy, R9 address held
    step(1, 8'h06, 1, 8'h34, 1, mk("R6", 8'h06, 1, 3'b010, 2'b00, 1, 8'h34));
    for (int k = 1; k < WRC; k++) begin
      if (k == 2)
        step(1, 8'hD8, 1, 8'h99, 1, mk("R8", 8'h02, 1, 3'b010, 2'b00, 1, 8'h34));
      else
        step(0, 8'h00, 1, 8'h99, 1,
             mk("R9", (k > 2) ? 8'h02 : 8'h06, 1, 3'b010, 2'b00, 1, 8'h34));
    end
    step(0, 8'h00, 1, 8'h99, 1, mk("R6", 8'h00, 0, 3'b000, 2'b00, 0, 0));

    // R13 read and write requested together
    step(1, 8'h07, 1, 8'h21, 1, mk("R13", 8'h06, 1, 3'b010, 2'b00, 1, 8'h21));
    idle(WRC - 1);
    step(0, 8'h00, 1, 8'h21, 1, mk("R13", 8'h04, 0, 3'b000, 2'b00, 0, 0));

    // R7 row erase in flash space
    step(1, 8'h96, 1, 8'h40, 1, mk("R7", 8'h96, 1, 3'b001, 2'b01, 1, 8'h40));
    idle(WRC - 2);
    step(0, 8'h00, 1, 8'h40, 1, mk("R7", 8'h96, 1, 3'b001, 2'b01, 1, 8'h40));
    step(0, 8'h00, 1, 8'h40, 1, mk("R7", 8'h84, 0, 3'b000, 2'b01, 0, 0));

    // R10 warm reset aborts a cycle
    step(1, 8'hC6, 1, 8'h55, 1, mk("R10", 8'hC6, 1, 3'b010, 2'b10, 1, 8'h55));
    idle(2);
    step(0, 8'h00, 0, 8'h55, 1, mk("R10", 8'hC8, 0, 3'b000, 2'b10, 0, 0));
    idle(WRC);
    step(0, 8'h00, 1, 8'h55, 1, mk("R10", 8'hC8, 0, 3'b000, 2'b10, 0, 0));

    // R12 normal completion clears the error flag
    step(1, 8'h0E, 1, 8'h66, 1, mk("R12", 8'h0E, 1, 3'b010, 2'b00, 1, 8'h66));
    idle(WRC - 1);
    step(0, 8'h00, 1, 8'h66, 1, mk("R12", 8'h04, 0, 3'b000, 2'b00, 0, 0));

    // R11 warm reset while idle
    step(1, 8'h8C, 1, 8'h00, 1, mk("R11", 8'h8C, 0, 3'b000, 2'b01, 0, 0));
    step(0, 8'h00, 0, 8'h00, 1, mk("R11", 8'h88, 0, 3'b000, 2'b01, 0, 0));
    step(0, 8'h00, 1, 8'h00, 1, mk("R11", 8'h88, 0, 3'b000, 2'b01, 0, 0));

    // R1 power-on reset clears persistent bits too
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 8'h00, 1, 8'h00, 1, mk("R1", 8'h00, 0, 3'b000, 2'b00, 1, 8'h00));

    idle(2);
    done = 1'b1;
    report();
  end
endmodule